// File: doc/BRIEF.md
# DRAM Idle Power-Mode Controller

This block lives inside a DRAM controller and decides when the memory may drop into a low-power state. It counts how long the request path has been quiet: no request presented and every internal queue empty. Once that count reaches a programmed threshold, it orders the DRAM into one of two states, chosen by configuration: precharge power-down or self-refresh. A fresh request brings the DRAM back. The DRAM command timing engine is outside the block. It sees one-cycle entry and exit strobes and answers each with a one-cycle `cmd_done`.

The block also decides whether the PHY may stop the DRAM clock. That depends on three things: the memory family, the clock-stop enable, and the present power state. On wake-up the clock comes back first. The exit command follows only after a programmed settle count has passed.

Requests use a valid/ready pair:
- A request that sees `req_ready` low must hold `req_valid` high until ready rises.
- Ready is high only in normal operation with the DRAM clock running.
- A request that arrives while an entry is in flight waits for that entry to finish. It then starts an exit at once.

Top module: `dram_lp_ctrl`

## Requirements
- R1: An entry strobe is raised once `cfg_idle_cycles` = N consecutive clock edges have passed with `req_valid`=0 and `queues_empty`=1. Any busy cycle restarts the count.
- R2: With only `cfg_pd_en` set, entry raises `pd_enter`. After `cmd_done`, `mode_sts` reads 2. A request leads to a `pd_exit` strobe, and after the next `cmd_done`, `mode_sts` reads 1.
- R3: With only `cfg_sr_en` set, entry raises `sr_enter`. After `cmd_done`, `mode_sts` reads 3. A request leads to `sr_exit`, and after `cmd_done`, `mode_sts` reads 1.
- R4: When both enables are set, `cfg_err` is 1, no entry strobe is ever raised, and `mode_sts` stays 1.
- R5: With `cfg_mem_lp`=0 (DDR2/DDR3 family), `phy_clk_en` can be 0 only in self-refresh. Power-down and idle keep the clock running.
- R6: With `cfg_mem_lp`=1 (LPDDR2 family) and clock stop enabled, the clock stops in power-down and in self-refresh. It also stops in normal operation once idle if no single mode is enabled. A request restarts it in that same cycle.
- R7: With `cfg_clkstop_en`=0, `phy_clk_en` is always 1.
- R8: On wake, `phy_clk_en` is 1 from the cycle after the request is seen. The exit strobe appears exactly `cfg_settle_cycles` = S clock edges later.
- R9: A request presented during entry sees `req_ready`=0 and `mode_sts`=1 until `cmd_done`. The block then goes straight into the wake sequence of R8.
- R10: `mode_sts` reads 1 for normal (including entry in flight), 2 for power-down, and 3 for self-refresh. `req_ready` is 0 whenever `mode_sts` is not 1. It is 1 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_pd_en | input | 1 | Enable idle-driven precharge power-down |
| cfg_sr_en | input | 1 | Enable idle-driven self-refresh |
| cfg_clkstop_en | input | 1 | Allow DRAM clock stopping |
| cfg_mem_lp | input | 1 | 1 = LPDDR2 family, 0 = DDR2/DDR3 family |
| cfg_idle_cycles | input | IDLE_W | Quiet cycles before idle is declared |
| cfg_settle_cycles | input | SETTLE_W | Cycles between clock restart and exit command |
| req_valid | input | 1 | A new request is presented |
| req_ready | output | 1 | Request may be accepted |
| queues_empty | input | 1 | All internal request queues are empty |
| pd_enter | output | 1 | Strobe: enter precharge power-down |
| pd_exit | output | 1 | Strobe: leave precharge power-down |
| sr_enter | output | 1 | Strobe: enter self-refresh |
| sr_exit | output | 1 | Strobe: leave self-refresh |
| cmd_done | input | 1 | Timing engine finished the last entry or exit |
| phy_clk_en | output | 1 | DRAM clock enable to the PHY |
| mode_sts | output | 2 | Current power mode (1, 2, 3) |
| cfg_err | output | 1 | Both power modes enabled together |

## Verification
The bench sweeps mode, memory family, clock-stop enable, idle threshold and settle count, and measures each delay in clock edges. An off-by-one in the idle or settle counter shows up as the strobe arriving one edge early or late. The clock-stop table is checked in every combination. A design that stopped the clock in DDR power-down, or ignored the enable, would show the wrong `phy_clk_en` while in the low-power state. A request landing during entry is the hardest case. A design that dropped it would stay parked in the low-power state, and one that let it through would raise ready before the DRAM is usable. Both enables set at once must produce no entry at all, however long the bus stays quiet.

// File: rtl/dlp_pkg.sv
package dlp_pkg;
  typedef enum logic [2:0] {
    ST_NORM,
    ST_ENTER,
    ST_LOWP,
    ST_WAKE,
    ST_EXIT
  } lp_state_t;

  localparam logic [1:0] MODE_NORM = 2'd1;
  localparam logic [1:0] MODE_PD   = 2'd2;
  localparam logic [1:0] MODE_SR   = 2'd3;
endpackage

// File: rtl/dlp_span_cnt.sv
// Saturating run-length counter: counts consecutive enabled edges since the
// last clear, and flags when the run has reached the programmed limit.
module dlp_span_cnt #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  input  logic         run,
  input  logic [W-1:0] limit,
  output logic         hit
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)              cnt <= '0;
    else if (clear || !run)  cnt <= '0;
    else if (cnt != '1)      cnt <= cnt + 1'b1;
  end

  assign hit = (cnt >= limit);
endmodule

// File: rtl/dlp_fsm.sv
module dlp_fsm
  import dlp_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      go,
  input  logic      go_sr,
  input  logic      req_valid,
  input  logic      cmd_done,
  input  logic      settle_hit,
  output lp_state_t state,
  output logic      kind_sr,
  output logic      exit_go
);
  lp_state_t nxt;

  assign exit_go = (state == ST_WAKE) && settle_hit;

  always_comb begin
    nxt = state;
    unique case (state)
      ST_NORM:  if (go) nxt = ST_ENTER;
      ST_ENTER: if (cmd_done) nxt = req_valid ? ST_WAKE : ST_LOWP;
      ST_LOWP:  if (req_valid) nxt = ST_WAKE;
      ST_WAKE:  if (settle_hit) nxt = ST_EXIT;
      ST_EXIT:  if (cmd_done) nxt = ST_NORM;
      default:  nxt = ST_NORM;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_NORM;
      kind_sr <= 1'b0;
    end else begin
      state <= nxt;
      if (state == ST_NORM && go) kind_sr <= go_sr;
    end
  end
endmodule

// File: rtl/dlp_clk_policy.sv
module dlp_clk_policy
  import dlp_pkg::*;
(
  input  lp_state_t state,
  input  logic      kind_sr,
  input  logic      mem_lp,
  input  logic      clkstop_en,
  input  logic      norm_idle,
  output logic      clk_en
);
  always_comb begin
    clk_en = 1'b1;
    if (clkstop_en) begin
      unique case (state)
        ST_LOWP: clk_en = !(kind_sr || mem_lp);
        ST_NORM: clk_en = !(mem_lp && norm_idle);
        default: clk_en = 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/dram_lp_ctrl.sv
module dram_lp_ctrl
  import dlp_pkg::*;
#(
  parameter int IDLE_W   = 8,
  parameter int SETTLE_W = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_pd_en,
  input  logic                cfg_sr_en,
  input  logic                cfg_clkstop_en,
  input  logic                cfg_mem_lp,
  input  logic [IDLE_W-1:0]   cfg_idle_cycles,
  input  logic [SETTLE_W-1:0] cfg_settle_cycles,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic                queues_empty,
  output logic                pd_enter,
  output logic                pd_exit,
  output logic                sr_enter,
  output logic                sr_exit,
  input  logic                cmd_done,
  output logic                phy_clk_en,
  output logic [1:0]          mode_sts,
  output logic                cfg_err
);
  lp_state_t state;
  logic      kind_sr, exit_go, idle_hit, settle_hit;
  logic      quiet, one_mode, go;

  assign quiet    = !req_valid && queues_empty;
  assign one_mode = cfg_pd_en ^ cfg_sr_en;
  assign cfg_err  = cfg_pd_en && cfg_sr_en;
  assign go       = (state == ST_NORM) && idle_hit && quiet && one_mode;

  dlp_span_cnt #(.W(IDLE_W)) u_idle (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (state != ST_NORM),
    .run   (quiet),
    .limit (cfg_idle_cycles),
    .hit   (idle_hit)
  );

  dlp_span_cnt #(.W(SETTLE_W)) u_settle (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (state != ST_WAKE),
    .run   (1'b1),
    .limit (cfg_settle_cycles),
    .hit   (settle_hit)
  );

  dlp_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .go         (go),
    .go_sr      (cfg_sr_en),
    .req_valid  (req_valid),
    .cmd_done   (cmd_done),
    .settle_hit (settle_hit),
    .state      (state),
    .kind_sr    (kind_sr),
    .exit_go    (exit_go)
  );

  dlp_clk_policy u_clk (
    .state      (state),
    .kind_sr    (kind_sr),
    .mem_lp     (cfg_mem_lp),
    .clkstop_en (cfg_clkstop_en),
    .norm_idle  (idle_hit && quiet && !one_mode),
    .clk_en     (phy_clk_en)
  );

  assign pd_enter  = go && cfg_pd_en;
  assign sr_enter  = go && cfg_sr_en;
  assign pd_exit   = exit_go && !kind_sr;
  assign sr_exit   = exit_go && kind_sr;
  assign req_ready = (state == ST_NORM) && phy_clk_en;

  always_comb begin
    if (state == ST_NORM || state == ST_ENTER) mode_sts = MODE_NORM;
    else mode_sts = kind_sr ? MODE_SR : MODE_PD;
  end
endmodule

// File: rtl/dlp_checker.sv
module dlp_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       cfg_clkstop_en,
  input logic       cfg_mem_lp,
  input logic       req_ready,
  input logic       pd_enter,
  input logic       pd_exit,
  input logic       sr_enter,
  input logic       sr_exit,
  input logic       phy_clk_en,
  input logic [1:0] mode_sts,
  input logic       cfg_err
);
  p_strobe_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({pd_enter, pd_exit, sr_enter, sr_exit}));

  p_enter_pending_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (pd_enter || sr_enter) |=> (mode_sts == 2'd1));

  p_no_entry_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> !(pd_enter || sr_enter));

  p_ddr_clk_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_mem_lp && !phy_clk_en) |-> (mode_sts == 2'd3));

  p_clk_kept_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_clkstop_en |-> phy_clk_en);

  p_exit_clk_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (pd_exit || sr_exit) |-> phy_clk_en);

  p_ready_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sts != 2'd1) |-> !req_ready);
endmodule

bind dram_lp_ctrl dlp_checker u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .cfg_clkstop_en (cfg_clkstop_en),
  .cfg_mem_lp     (cfg_mem_lp),
  .req_ready      (req_ready),
  .pd_enter       (pd_enter),
  .pd_exit        (pd_exit),
  .sr_enter       (sr_enter),
  .sr_exit        (sr_exit),
  .phy_clk_en     (phy_clk_en),
  .mode_sts       (mode_sts),
  .cfg_err        (cfg_err)
);

// File: tb/sim_dram_lp_ctrl.sv
module sim_dram_lp_ctrl;
  localparam int IW = 8;
  localparam int SW = 4;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic          rst_n, pd_en, sr_en, cs_en, mem_lp;
  logic [IW-1:0] idle_n;
  logic [SW-1:0] settle_n;
  logic          req_valid, req_ready, qe, cmd_done;
  logic          pd_enter, pd_exit, sr_enter, sr_exit, clk_en, cfg_err;
  logic [1:0]    mode;

  dram_lp_ctrl #(.IDLE_W(IW), .SETTLE_W(SW)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_pd_en(pd_en), .cfg_sr_en(sr_en),
    .cfg_clkstop_en(cs_en), .cfg_mem_lp(mem_lp), .cfg_idle_cycles(idle_n),
    .cfg_settle_cycles(settle_n), .req_valid(req_valid), .req_ready(req_ready),
    .queues_empty(qe), .pd_enter(pd_enter), .pd_exit(pd_exit),
    .sr_enter(sr_enter), .sr_exit(sr_exit), .cmd_done(cmd_done),
    .phy_clk_en(clk_en), .mode_sts(mode), .cfg_err(cfg_err)
  );

  int total = 0;
  int bad = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  // Counts edges until an entry (which=0) or exit (which=1) strobe is seen.
  task automatic wait_strobe(input int which, output int n);
    n = -1;
    for (int k = 0; k < 40; k++) begin
      #1;
      if ((which == 0 && (pd_enter || sr_enter)) || (which == 1 && (pd_exit || sr_exit))) begin
        n = k;
        break;
      end
      tick();
    end
  endtask

  task automatic start_quiet();
    req_valid = 1'b1;
    tick();
    req_valid = 1'b0;
  endtask

  task automatic lp_run(input bit ksr, input bit lp, input bit cs, input int n, input int s);
    int got;
    bit exp_clk;
    string tag;
    tag = ksr ? "R3" : "R2";
    pd_en = !ksr; sr_en = ksr; mem_lp = lp; cs_en = cs;
    idle_n = IW'(n); settle_n = SW'(s);
    start_quiet();
    wait_strobe(0, got);
    chk(got == n, "R1 idle edges", got, n);
    chk(sr_enter == ksr && pd_enter == !ksr, tag, int'(sr_enter), int'(ksr));
    tick();
    #1;
    chk(!req_ready && mode == 2'd1, "R10 entry in flight", int'(mode), 1);
    cmd_done = 1'b1;
    tick();
    cmd_done = 1'b0;
    #1;
    chk(mode == (ksr ? 2'd3 : 2'd2), tag, int'(mode), ksr ? 3 : 2);
    exp_clk = !(cs && (ksr || lp));
    chk(clk_en == exp_clk, !cs ? "R7" : (lp ? "R6" : "R5"), int'(clk_en), int'(exp_clk));
    tick();
    tick();
    req_valid = 1'b1;
    #1;
    chk(!req_ready, "R10 low power", int'(req_ready), 0);
    tick();
    #1;
    chk(clk_en == 1'b1, "R8 clock first", int'(clk_en), 1);
    wait_strobe(1, got);
    chk(got == s, "R8 settle edges", got, s);
    chk(sr_exit == ksr && pd_exit == !ksr, tag, int'(sr_exit), int'(ksr));
    tick();
    cmd_done = 1'b1;
    tick();
    cmd_done = 1'b0;
    #1;
    chk(mode == 2'd1 && req_ready, tag, int'(mode), 1);
    req_valid = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog (all requirements) actual=0 expected=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int got;
    bit any;
    rst_n = 1'b0; pd_en = 0; sr_en = 0; cs_en = 0; mem_lp = 0;
    idle_n = '0; settle_n = '0; req_valid = 0; qe = 1; cmd_done = 0;
    repeat (3) tick();
    rst_n = 1'b1;
    #1;
    chk(mode == 2'd1 && req_ready && clk_en, "R10 reset", int'(mode), 1);
    chk(!(pd_enter || sr_enter || pd_exit || sr_exit), "R10 reset strobes", 1, 0);

    // Full sweep of R2/R3/R5/R6/R7/R8 over a small configuration space.
    for (int ksr = 0; ksr < 2; ksr++)
      for (int lp = 0; lp < 2; lp++)
        for (int cs = 0; cs < 2; cs++)
          for (int ni = 0; ni < 2; ni++)
            for (int si = 0; si < 2; si++)
              lp_run(ksr[0], lp[0], cs[0], ni == 0 ? 1 : 3, si == 0 ? 0 : 2);

    // R1: a busy queue cycle restarts the idle count.
    pd_en = 1; sr_en = 0; mem_lp = 0; cs_en = 0; idle_n = 4; settle_n = 1;
    start_quiet();
    tick(); tick();
    qe = 1'b0;
    tick();
    qe = 1'b1;
    wait_strobe(0, got);
    chk(got == 4, "R1 restart after busy", got, 4);
    tick();
    cmd_done = 1; tick(); cmd_done = 0;
    req_valid = 1; tick();
    wait_strobe(1, got);
    tick(); cmd_done = 1; tick(); cmd_done = 0; req_valid = 0;

    // R4: both enables set.
    pd_en = 1; sr_en = 1; mem_lp = 1; cs_en = 1; idle_n = 2;
    start_quiet();
    any = 0;
    for (int k = 0; k < 12; k++) begin
      #1;
      if (pd_enter || sr_enter) any = 1;
      tick();
    end
    chk(!any, "R4 no entry", int'(any), 0);
    chk(cfg_err && mode == 2'd1, "R4 error flag", int'(cfg_err), 1);

    // R6: LPDDR2 normal-idle clock stop with no mode enabled.
    pd_en = 0; sr_en = 0; mem_lp = 1; cs_en = 1; idle_n = 3;
    start_quiet();
    tick(); tick();
    #1;
    chk(clk_en == 1'b1, "R6 before idle", int'(clk_en), 1);
    tick();
    #1;
    chk(clk_en == 1'b0, "R6 idle stop", int'(clk_en), 0);
    req_valid = 1'b1;
    #1;
    chk(clk_en && req_ready, "R6 request restart", int'(clk_en), 1);
    tick();
    req_valid = 1'b0;

    // R5: DDR family keeps clock in normal idle.
    mem_lp = 0;
    start_quiet();
    repeat (5) tick();
    #1;
    chk(clk_en == 1'b1, "R5 idle keeps clock", int'(clk_en), 1);

    // R9: request during entry.
    pd_en = 1; sr_en = 0; mem_lp = 1; cs_en = 1; idle_n = 1; settle_n = 2;
    start_quiet();
    wait_strobe(0, got);
    tick();
    req_valid = 1'b1;
    #1;
    chk(!req_ready, "R9 held during entry", int'(req_ready), 0);
    tick(); tick();
    #1;
    chk(!req_ready && mode == 2'd1, "R9 still held", int'(mode), 1);
    cmd_done = 1'b1;
    tick();
    cmd_done = 1'b0;
    #1;
    chk(clk_en && mode == 2'd2 && !req_ready, "R9 direct wake", int'(clk_en), 1);
    wait_strobe(1, got);
    chk(got == 2 && pd_exit, "R9 exit after settle", got, 2);
    tick();
    cmd_done = 1'b1;
    tick();
    cmd_done = 1'b0;
    #1;
    chk(mode == 2'd1 && req_ready, "R9 back to normal", int'(mode), 1);
    req_valid = 1'b0;

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule